// File: doc/BRIEF.md
# Overlap-Add Block Convolution Engine

This block computes the complete linear convolution of a finite input sequence with a finite impulse response. The input is split into equal, consecutive segments. Each segment is convolved on its own with the whole impulse response, and each segment's partial result is added into a shared output store at that segment's starting position. Because every segment's result is longer than the segment, the tails of neighbouring results overlap, and adding them rebuilds the full convolution.

Software or a sequencer writes the input samples and the impulse-response taps through two addressed write ports with valid/ready handshakes. A start pulse then launches the computation. All products go through one registered multiplier, one product per clock. When the last product has been added, a done flag rises. The result is then read through an addressed read port.

Top module: `ola_conv_top`

## Requirements
- R1: After reset, `busy` and `done` are low and both write ports show ready high.
- R2: While the engine is not busy, a write port stores `wr_data` at `wr_addr` on every clock in which valid and ready are both high.
- R3: After done, read address n (0 to 510) returns y[n] = sum over k of x[k]·h[n−k], using 256 input samples and 256 taps. This is the full linear convolution, with 511 outputs.
- R4: The input is processed as 16 segments of 16 samples. Segment s contributes its products to output indices 16·s through 16·s+270, so the last 255 entries of each segment's result overlap the next segments' results and are summed with them.
- R5: Samples and taps are 8-bit two's complement. Outputs are 24-bit two's complement and exact. The extreme case of all samples and all taps equal to −128 gives 4194304 at index 255.
- R6: While busy, both write ports hold ready low, and write attempts change no stored sample or tap.
- R7: `done` stays high until the next accepted start. A start that arrives while busy is ignored and does not restart or delay the run.
- R8: The clock edge that accepts start is edge 1. `busy` is high after edges 1 through 65537, and `done` rises after edge 65538 (65536 products issued one per clock, two register stages behind them).
- R9: An accepted start clears every output entry, so a second run's results do not include the first run's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_wr_valid | input | 1 | Input-sample write request |
| x_wr_ready | output | 1 | Input-sample write accepted (low while busy) |
| x_wr_addr | input | 8 | Input-sample index |
| x_wr_data | input | 8 | Input-sample value, signed |
| h_wr_valid | input | 1 | Tap write request |
| h_wr_ready | output | 1 | Tap write accepted (low while busy) |
| h_wr_addr | input | 8 | Tap index |
| h_wr_data | input | 8 | Tap value, signed |
| start | input | 1 | Launch pulse |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Result complete, held until next start |
| rd_addr | input | 9 | Output index to read |
| rd_data | output | 24 | Output value at rd_addr, signed |

## Verification
The hardest behaviour to reach from the ports is a write or a second start that arrives in the middle of a run. The reason is that the run itself gives no handle on the stored data apart from the final result. The stimulus therefore aims these disturbances at data the run has not used yet. It offers a tap write during the first run and does not reload the taps afterwards, so the second run's result shows whether the write slipped through. During the second run it offers an input-sample write to an index that has not yet been read, and a start pulse. The cycle-exact busy/done model then shows any restart or delay.

// File: rtl/ola_pkg.sv
package ola_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_DONE = 2'd2
    } eng_state_t;

    // Flags that travel with each product through the pipeline
    typedef struct packed {
        logic vld;
        logic last;
    } mac_tag_t;

    function automatic int conv_len(input int xl, input int hl);
        return xl + hl - 1;
    endfunction

    function automatic int acc_width(input int dw, input int hl);
        return 2 * dw + $clog2(hl);
    endfunction

endpackage

// File: rtl/ola_segmenter.sv
module ola_segmenter
    import ola_pkg::*;
#(
    parameter int XLEN = 256,
    parameter int HLEN = 256,
    parameter int BLK  = 16,
    localparam int NBLK = XLEN / BLK,
    localparam int XAW  = $clog2(XLEN),
    localparam int HAW  = $clog2(HLEN),
    localparam int OLEN = conv_len(XLEN, HLEN),
    localparam int OAW  = $clog2(OLEN),
    localparam int NBW  = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int SBW  = (BLK > 1) ? $clog2(BLK) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           launch,
    output mac_tag_t       tag,
    output logic [XAW-1:0] x_addr,
    output logic [HAW-1:0] h_addr,
    output logic [OAW-1:0] out_idx
);

    logic           active;
    logic [NBW-1:0] blk_q;
    logic [SBW-1:0] smp_q;
    logic [HAW-1:0] tap_q;

    logic tap_end, smp_end, blk_end;
    assign tap_end = (tap_q == HAW'(HLEN - 1));
    assign smp_end = (smp_q == SBW'(BLK - 1));
    assign blk_end = (blk_q == NBW'(NBLK - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            blk_q  <= '0;
            smp_q  <= '0;
            tap_q  <= '0;
        end else if (launch) begin
            active <= 1'b1;
            blk_q  <= '0;
            smp_q  <= '0;
            tap_q  <= '0;
        end else if (active) begin
            if (!tap_end) begin
                tap_q <= tap_q + 1'b1;
            end else begin
                tap_q <= '0;
                if (!smp_end) begin
                    smp_q <= smp_q + 1'b1;
                end else begin
                    smp_q <= '0;
                    if (!blk_end) begin
                        blk_q <= blk_q + 1'b1;
                    end else begin
                        blk_q  <= '0;
                        active <= 1'b0;
                    end
                end
            end
        end
    end

    logic [OAW-1:0] seg_base;
    assign seg_base = OAW'(int'(blk_q) * BLK);

    always_comb begin
        tag.vld  = active;
        tag.last = active && tap_end && smp_end && blk_end;
        x_addr   = XAW'(int'(blk_q) * BLK + int'(smp_q));
        h_addr   = tap_q;
        out_idx  = seg_base + OAW'(smp_q) + OAW'(tap_q);
    end

    // R3: every issued product targets a real output entry
    p_idx_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        tag.vld |-> (out_idx < OAW'(OLEN)));

    // R4: inside a segment sample, successive taps land on successive outputs
    p_tap_walk_r4: assert property (@(posedge clk) disable iff (rst)
        (tag.vld && !tap_end && !launch) |=> (tag.vld && out_idx == $past(out_idx) + 1'b1));

endmodule

// File: rtl/ola_mult.sv
module ola_mult
    import ola_pkg::*;
#(
    parameter int DW = 8,
    parameter int IW = 9,
    localparam int PW = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  mac_tag_t             in_tag,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    input  logic        [IW-1:0] in_idx,
    output mac_tag_t             out_tag,
    output logic signed [PW-1:0] prod,
    output logic        [IW-1:0] out_idx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_tag <= '0;
        end else begin
            out_tag <= in_tag;
        end
    end

    always_ff @(posedge clk) begin
        prod    <= a * b;
        out_idx <= in_idx;
    end

    // R8: one product leaves one clock after it enters
    p_one_stage_r8: assert property (@(posedge clk) disable iff (rst)
        in_tag.vld |=> out_tag.vld);

endmodule

// File: rtl/ola_accum.sv
module ola_accum #(
    parameter int AW   = 24,
    parameter int PW   = 16,
    parameter int OLEN = 511,
    localparam int OAW = $clog2(OLEN)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  add_en,
    input  logic        [OAW-1:0] add_idx,
    input  logic signed [PW-1:0]  add_val,
    input  logic        [OAW-1:0] rd_addr,
    output logic signed [AW-1:0]  rd_data
);

    logic signed [AW-1:0] acc_mem [OLEN];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < OLEN; i++) begin
                acc_mem[i] <= '0;
            end
        end else if (add_en) begin
            acc_mem[add_idx] <= acc_mem[add_idx] + AW'(add_val);
        end
    end

    always_comb begin
        if (rd_addr < OAW'(OLEN)) begin
            rd_data = acc_mem[rd_addr];
        end else begin
            rd_data = '0;
        end
    end

    // R9: a clear leaves the first and the last entries at zero
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && !add_en) |=> (acc_mem[0] == '0 && acc_mem[OLEN-1] == '0));

endmodule

// File: rtl/ola_conv_top.sv
module ola_conv_top
    import ola_pkg::*;
#(
    parameter int DW   = 8,
    parameter int XLEN = 256,
    parameter int HLEN = 256,
    parameter int BLK  = 16,
    localparam int XAW  = $clog2(XLEN),
    localparam int HAW  = $clog2(HLEN),
    localparam int OLEN = conv_len(XLEN, HLEN),
    localparam int OAW  = $clog2(OLEN),
    localparam int AW   = acc_width(DW, HLEN),
    localparam int PW   = 2 * DW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 x_wr_valid,
    output logic                 x_wr_ready,
    input  logic [XAW-1:0]       x_wr_addr,
    input  logic signed [DW-1:0] x_wr_data,
    input  logic                 h_wr_valid,
    output logic                 h_wr_ready,
    input  logic [HAW-1:0]       h_wr_addr,
    input  logic signed [DW-1:0] h_wr_data,
    input  logic                 start,
    output logic                 busy,
    output logic                 done,
    input  logic [OAW-1:0]       rd_addr,
    output logic signed [AW-1:0] rd_data
);

    eng_state_t state_q;
    logic       accept;

    logic signed [DW-1:0] x_mem [XLEN];
    logic signed [DW-1:0] h_mem [HLEN];

    mac_tag_t             seg_tag, mul_tag;
    logic [XAW-1:0]       seg_xa;
    logic [HAW-1:0]       seg_ha;
    logic [OAW-1:0]       seg_oi, mul_oi;
    logic signed [PW-1:0] mul_p;

    assign busy       = (state_q == ENG_RUN);
    assign done       = (state_q == ENG_DONE);
    assign accept     = start && !busy;
    assign x_wr_ready = !busy;
    assign h_wr_ready = !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
        end else if (accept) begin
            state_q <= ENG_RUN;
        end else if (busy && mul_tag.vld && mul_tag.last) begin
            state_q <= ENG_DONE;
        end
    end

    always_ff @(posedge clk) begin
        if (x_wr_valid && x_wr_ready) begin
            x_mem[x_wr_addr] <= x_wr_data;
        end
        if (h_wr_valid && h_wr_ready) begin
            h_mem[h_wr_addr] <= h_wr_data;
        end
    end

    ola_segmenter #(.XLEN(XLEN), .HLEN(HLEN), .BLK(BLK)) u_seg (
        .clk     (clk),
        .rst     (rst),
        .launch  (accept),
        .tag     (seg_tag),
        .x_addr  (seg_xa),
        .h_addr  (seg_ha),
        .out_idx (seg_oi)
    );

    ola_mult #(.DW(DW), .IW(OAW)) u_mul (
        .clk     (clk),
        .rst     (rst),
        .in_tag  (seg_tag),
        .a       (x_mem[seg_xa]),
        .b       (h_mem[seg_ha]),
        .in_idx  (seg_oi),
        .out_tag (mul_tag),
        .prod    (mul_p),
        .out_idx (mul_oi)
    );

    ola_accum #(.AW(AW), .PW(PW), .OLEN(OLEN)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .add_en  (mul_tag.vld),
        .add_idx (mul_oi),
        .add_val (mul_p),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // R7: done holds until a start is presented
    p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R7: a start taken from done relaunches the engine
    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> (busy && !done));

    // R8: products are issued only while the engine runs
    p_issue_in_run_r8: assert property (@(posedge clk) disable iff (rst)
        seg_tag.vld |-> busy);

    // R6: a stored tap does not move while busy
    p_taps_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(h_mem[0]));

endmodule

// File: tb/sim_ola_conv_top.sv
`timescale 1ns/1ps
module sim_ola_conv_top;

    localparam int XL  = 256;
    localparam int HL  = 256;
    localparam int OL  = XL + HL - 1;
    localparam int DONE_EDGE = XL * HL + 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        x_wr_valid, h_wr_valid;
    logic        x_wr_ready, h_wr_ready;
    logic [7:0]  x_wr_addr, h_wr_addr;
    logic signed [7:0] x_wr_data, h_wr_data;
    logic        start;
    logic        busy, done;
    logic [8:0]  rd_addr;
    logic signed [23:0] rd_data;

    int checks = 0;
    int errors = 0;
    int mx [XL];
    int mh [HL];

    always #2.5 clk = ~clk;

    ola_conv_top u0 (
        .clk(clk), .rst(rst),
        .x_wr_valid(x_wr_valid), .x_wr_ready(x_wr_ready),
        .x_wr_addr(x_wr_addr), .x_wr_data(x_wr_data),
        .h_wr_valid(h_wr_valid), .h_wr_ready(h_wr_ready),
        .h_wr_addr(h_wr_addr), .h_wr_data(h_wr_data),
        .start(start), .busy(busy), .done(done),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        summary();
    end

    task automatic load_x(input int mode);
        for (int i = 0; i < XL; i++) begin
            @(negedge clk);
            chk("R2 x ready", x_wr_ready, 1);
            mx[i] = (mode == 0) ? -128 : ($urandom_range(0, 255) - 128);
            x_wr_valid = 1'b1;
            x_wr_addr  = 8'(i);
            x_wr_data  = 8'(mx[i]);
        end
        @(negedge clk);
        x_wr_valid = 1'b0;
    endtask

    task automatic load_h();
        for (int i = 0; i < HL; i++) begin
            @(negedge clk);
            chk("R2 h ready", h_wr_ready, 1);
            mh[i] = -128;
            h_wr_valid = 1'b1;
            h_wr_addr  = 8'(i);
            h_wr_data  = 8'(mh[i]);
        end
        @(negedge clk);
        h_wr_valid = 1'b0;
    endtask

    // inject: 0 offers a tap write, 1 offers an input write (both refused, R6)
    task automatic run(input int inject);
        @(negedge clk);
        start = 1'b1;
        for (int n = 1; n <= DONE_EDGE + 3; n++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R8 busy", busy, (n < DONE_EDGE) ? 1 : 0);
            chk("R8 done", done, (n >= DONE_EDGE) ? 1 : 0);
            chk("R6 ready", x_wr_ready && h_wr_ready, (n < DONE_EDGE) ? 0 : 1);
            start = 1'b0;
            x_wr_valid = 1'b0;
            h_wr_valid = 1'b0;
            if (n == 100) begin
                start = 1'b1; // R7: ignored while busy
                if (inject == 0) begin
                    h_wr_valid = 1'b1; h_wr_addr = 8'd3; h_wr_data = 8'sd77;
                end else begin
                    x_wr_valid = 1'b1; x_wr_addr = 8'd5; x_wr_data = 8'(~mx[5]);
                end
            end
        end
        chk("R7 done held", done, 1);
    endtask

    task automatic compare(input string req);
        for (int n = 0; n < OL; n++) begin
            longint exp = 0;
            for (int k = 0; k < XL; k++) begin
                if (n - k >= 0 && n - k < HL) exp += longint'(mx[k]) * longint'(mh[n - k]);
            end
            @(negedge clk);
            rd_addr = 9'(n);
            #1;
            chk(req, longint'(rd_data), exp);
        end
    endtask

    initial begin
        rst = 1'b1; start = 1'b0;
        x_wr_valid = 1'b0; h_wr_valid = 1'b0;
        x_wr_addr = '0; h_wr_addr = '0; x_wr_data = '0; h_wr_data = '0;
        rd_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 ready", x_wr_ready && h_wr_ready, 1);

        // run 1: extreme magnitudes, every segment tail overlaps (R4, R5)
        load_x(0);
        load_h();
        run(0);
        compare("R3 R4 R5 extreme");
        @(negedge clk); rd_addr = 9'd255; #1;
        chk("R5 peak", longint'(rd_data), 4194304);
        @(negedge clk); rd_addr = 9'd510; #1;
        chk("R4 last tail", longint'(rd_data), 16384);

        // run 2: random input, taps kept from run 1 (the refused tap write must not show)
        load_x(1);
        run(1);
        compare("R3 R6 R9 random");
        summary();
    end

endmodule